// File: doc/BRIEF.md
# Periodic Memory Refresh Requester

This block keeps dynamic or pseudo-static memory alive by asking a bus arbiter, at a steady programmable rate, for a dummy memory read cycle. A down-counter spaces the requests. Each request carries a 20-bit address. A rolling row counter supplies the row part of that address, and a programmable block base places the refreshed region on any 8 KB boundary.

Software programs the block through a small write port with three targets: the interval, the block base and a run bit. The arbiter answers each request with a single-cycle grant. The block keeps at most one request open. If an interval expires while a request is still waiting, the two are merged into that one request. Bus timing and the memory devices themselves are handled outside this block.

Top module: `refresh_gen`

## Requirements
- R1: After reset the request output is 0, the address output is 0, the run bit is off, the interval register holds 511, the block base is 0 and the row counter is 0.
- R2: With the run bit on and interval value P, the request rises P+1 clocks after the counter starts from P. Later expiries also come every P+1 clocks. An interval of 0 expires on every clock.
- R3: A raised request stays high until a clock in which the grant input is high. It falls after that clock unless a new expiry happens in the same clock.
- R4: An expiry while a request is already waiting raises no second request. The row counter advances only once, when that request is granted.
- R5: The address output is {base[6:0], 3'b000, row[8:0], 1'b0}. Bits 19..13 are the base, bits 9..1 are the row, and bits 12..10 and bit 0 are always 0.
- R6: The row counter advances by one on every clock in which the request and the grant are both high. It wraps from 511 to 0.
- R7: While the run bit is off, no request is raised, a waiting request is withdrawn after one clock, and the counter is held at the interval value. Turning the run bit on restarts counting from the full interval.
- R8: A grant while no request is high has no effect on the row counter or on the request output.
- R9: When an expiry and a grant fall on the same clock, the request stays high for a new refresh and the row counter still advances.
- R10: Register select encoding: 0 writes the interval (data[8:0]), 1 writes the base (data[6:0]), 2 writes the run bit (data[0]). Select 3 is ignored. A new interval takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 interval, 1 base, 2 run bit) |
| cfg_wdata | input | 9 | Register write data |
| rfsh_req | output | 1 | Refresh request to the arbiter |
| rfsh_gnt | input | 1 | Grant from the arbiter, one clock per refresh |
| rfsh_addr | output | 20 | Refresh cycle address |

## Verification
A corrupted interval counter shows up as a request edge that comes one or more clocks early or late. The per-clock comparison catches this within the first refresh period. A bad row counter or base register shows at once on the address output, in the clock after the grant or the write that set it. Lost or duplicated requests show up as a request level that differs from the model in the clock after an unanswered expiry or a grant.

// File: rtl/refresh_gen.sv
module refresh_gen #(
  parameter int CNT_W  = 9,
  parameter int ROW_W  = 9,
  parameter int BASE_W = 7,
  parameter int ADDR_W = 20,
  parameter int DATA_W = 9,
  parameter logic [CNT_W-1:0] RST_INTERVAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              rfsh_req,
  input  logic              rfsh_gnt,
  output logic [ADDR_W-1:0] rfsh_addr
);
  localparam int BASE_LSB = ADDR_W - BASE_W;
  localparam int GAP_W    = BASE_LSB - ROW_W - 1;

  logic [CNT_W-1:0]  reload, cnt;
  logic [BASE_W-1:0] base;
  logic [ROW_W-1:0]  row;
  logic              en;

  wire expire = en && (cnt == '0);
  wire taken  = rfsh_req && rfsh_gnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reload <= RST_INTERVAL;
      base   <= '0;
      en     <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: reload <= cfg_wdata[CNT_W-1:0];
        2'd1: base   <= cfg_wdata[BASE_W-1:0];
        2'd2: en     <= cfg_wdata[0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= RST_INTERVAL;
    else if (!en || expire)    cnt <= reload;
    else                       cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rfsh_req <= 1'b0;
    else        rfsh_req <= expire || (en && rfsh_req && !rfsh_gnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     row <= '0;
    else if (taken) row <= row + 1'b1;

  assign rfsh_addr = {base, {GAP_W{1'b0}}, row, 1'b0};

  a_r3_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req && !rfsh_gnt && en) |=> rfsh_req);

  a_r2_rise_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_req) |-> $past(cnt) == '0);

  a_r7_off_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rfsh_req);

  a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> rfsh_addr[ROW_W:1] == $past(rfsh_addr[ROW_W:1]) + 1'b1);

  a_r8_row_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable(rfsh_addr[ROW_W:1]));

  a_r10_base_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> rfsh_addr[ADDR_W-1:BASE_LSB] == $past(cfg_wdata[BASE_W-1:0]));
endmodule

// File: tb/refresh_gen_test.sv
module refresh_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, cfg_we = 0, rfsh_gnt = 0;
  logic [1:0] cfg_sel = 0;
  logic [8:0] cfg_wdata = 0;
  logic rfsh_req;
  logic [19:0] rfsh_addr;

  int errors = 0, checks = 0, cycles = 0;
  int m_req, m_row, m_cnt, m_rel, m_base, m_en;
  string tag = "R1";
  bit auto_arb = 0;
  int arb_lat = 0, arb_wait = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_gen uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rfsh_req(rfsh_req), .rfsh_gnt(rfsh_gnt), .rfsh_addr(rfsh_addr));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_row = 0; m_cnt = 511; m_rel = 511; m_base = 0; m_en = 0;
    end else begin
      int nreq;
      if (m_req != 0 && rfsh_gnt) m_row = (m_row + 1) % 512;
      if (m_en == 0)        begin nreq = 0; m_cnt = m_rel; end
      else if (m_cnt == 0)  begin nreq = 1; m_cnt = m_rel; end
      else                  begin nreq = (m_req != 0 && !rfsh_gnt) ? 1 : 0; m_cnt = m_cnt - 1; end
      m_req = nreq;
      if (cfg_we) begin
        if (cfg_sel == 0) m_rel = cfg_wdata;
        else if (cfg_sel == 1) m_base = cfg_wdata % 128;
        else if (cfg_sel == 2) m_en = cfg_wdata % 2;
      end
    end
  end

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", t, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check({tag, " req"}, int'(rfsh_req), m_req);
      check({tag, " addr"}, int'(rfsh_addr), m_base * 8192 + m_row * 2);
    end
    if (auto_arb) begin
      if (rfsh_req && !rfsh_gnt) begin
        if (arb_wait >= arb_lat) begin rfsh_gnt = 1; arb_wait = 0; end
        else arb_wait++;
      end else rfsh_gnt = 0;
    end
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk); #1;
    cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = 9'(data);
    @(negedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic grant1();
    @(negedge clk); #1; rfsh_gnt = 1;
    @(negedge clk); #1; rfsh_gnt = 0;
  endtask

  initial begin
    int row_before;
    idle(3);
    check("R1 reset req", int'(rfsh_req), 0);
    check("R1 reset addr", int'(rfsh_addr), 0);
    #1 rst_n = 1;
    idle(3);
    check("R1 idle after reset", int'(rfsh_req), 0);

    tag = "R2";
    wr(0, 5); wr(1, 7'h55); wr(2, 1);
    idle(6);
    check("R2 request rises P+1 after enable", int'(rfsh_req), 1);
    check("R5 base and row fields", int'(rfsh_addr), 'h55 * 8192);

    tag = "R4"; idle(20);
    check("R4 still one pending request", int'(rfsh_req), 1);
    check("R4 row unchanged while waiting", int'(rfsh_addr[9:1]), 0);

    tag = "R3"; grant1();
    check("R6 row advanced once", int'(rfsh_addr[9:1]), 1);

    tag = "R8";
    @(negedge clk); #1;
    row_before = int'(rfsh_addr[9:1]);
    if (!rfsh_req) begin rfsh_gnt = 1; @(negedge clk); #1; rfsh_gnt = 0; end
    check("R8 stray grant leaves row", int'(rfsh_addr[9:1]), row_before);

    tag = "R10"; wr(3, 9'h1FF); idle(2);
    check("R10 select 3 ignored (base)", int'(rfsh_addr[19:13]), 'h55);
    wr(0, 2); idle(12);

    tag = "R7"; idle(4); wr(2, 0); idle(3);
    check("R7 disabled no request", int'(rfsh_req), 0);
    idle(10);
    check("R7 still none", int'(rfsh_req), 0);
    wr(2, 1); idle(5);

    tag = "R9"; wr(0, 0);
    @(negedge clk); #1; rfsh_gnt = 1;
    idle(600);
    check("R9 request held with back-to-back grants", int'(rfsh_req), 1);
    #1 rfsh_gnt = 0;

    tag = "R6"; wr(2, 0); idle(2);
    row_before = int'(rfsh_addr[9:1]);
    check("R6 row matches model after wrap", row_before, m_row);

    tag = "R2"; wr(0, 4); wr(1, 7'h0A); wr(2, 1);
    auto_arb = 1; arb_lat = 3; idle(200);
    auto_arb = 0; arb_lat = 0; idle(2); #1 rfsh_gnt = 0;
    tag = "R5"; idle(5);
    check("R5 zero gap bits", int'(rfsh_addr[12:10]) + int'(rfsh_addr[0]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule